// File: doc/BRIEF.md
# Bank Command Timing Guard

This block sits between a command scheduler and a single bank of a synchronous DRAM. Every cycle it tells the scheduler which of the four bank commands (open a row, read, write, close the row) may be issued now. The answer depends on the bank's open or closed status and on how many clock cycles have passed since the last row open and the last row close. A command issues only when the scheduler presents it and the matching allow line is high in the same cycle. A command that is presented but refused is dropped and leaves nothing behind.

Four cycle counts govern the timing. The first is read latency: read data returns that many cycles after the read. The second is open-to-access delay: reads and writes wait that long after a row open. The third is close recovery: a new row open waits that long after a close. The fourth is minimum open time: a close waits that long after a row open. A configuration port loads new counts at run time. Their reset values are 3, 4, 4 and 8. The block also raises a strobe in each cycle in which the bank is due to return read data.

The control is a four-state machine. IDLE means closed and ready to open. OPENING means open but still inside the open-to-access delay. ACTIVE means open with reads and writes permitted. PRECHARGING means closed and still inside close recovery. The transitions are:

- IDLE to OPENING on an issued open, or straight to ACTIVE when the open-to-access count is 0 or 1.
- OPENING to ACTIVE when the delay has elapsed.
- OPENING or ACTIVE to PRECHARGING on an issued close, or to IDLE when the recovery count is 0 or 1.
- PRECHARGING to IDLE when close recovery has elapsed.

Top module: `bank_timing_guard`

## Requirements
- R1: After reset the bank is closed and only an open is allowed. The read-return strobe is low, and the timing counts are latency 3, open-to-access 4, close recovery 4 and minimum open time 8.
- R2: Commands are encoded on cmd_type as 0 open, 1 read, 2 write and 3 close. A command issues only when cmd_valid and its own allow line are both high. A refused command changes no state, so a refused read to a closed bank leaves the bank closed and an open still allowed.
- R3: If an open issues in cycle c, read and write are allowed in every cycle from c plus the open-to-access count until the bank closes, and never while the bank is closed.
- R4: If an open issues in cycle c, a close is allowed from cycle c plus the minimum open time onward while the bank stays open, and never while it is closed.
- R5: If a close issues in cycle c, an open is allowed from cycle c plus the close recovery count onward, and never while the bank is open.
- R6: For every read issued in cycle c, rdata_expected is high in cycle c plus the latency. Reads may be issued on back-to-back cycles.
- R7: A configuration load is taken only under all of these conditions: the bank is in IDLE, no read data is still due, no open issues in that cycle, and the latency field is between 1 and CL_MAX (16). When taken, the new counts apply from the next cycle. Any other load is ignored.
- R8: bank_open goes high in the cycle after an issued open and low in the cycle after an issued close.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Request to load the four timing counts |
| cfg_cl | input | 6 | Read latency in cycles |
| cfg_rcd | input | 6 | Open-to-access delay in cycles |
| cfg_rp | input | 6 | Close recovery in cycles |
| cfg_ras | input | 6 | Minimum open time in cycles |
| cmd_valid | input | 1 | Scheduler presents a command |
| cmd_type | input | 2 | 0 open, 1 read, 2 write, 3 close |
| allow_act | output | 1 | An open may issue this cycle |
| allow_rd | output | 1 | A read may issue this cycle |
| allow_wr | output | 1 | A write may issue this cycle |
| allow_pre | output | 1 | A close may issue this cycle |
| bank_open | output | 1 | A row is open |
| rdata_expected | output | 1 | Read data is due this cycle |

## Verification
The bench targets the exact first cycle of each window: one cycle before the count and the cycle it is reached. A design that is off by one register would open that window one cycle early or late. It also issues a close as soon as the minimum open time allows while open-to-access is short, and a design that gated the close on open-to-access alone would close too early. Configuration loads are attempted while the bank is open, during recovery and with reads still in flight. A design that took such a load would move later windows and shift pending read strobes, and the cycle-stamped reference model would see it. Refused commands to the wrong bank state check that a careless design does not restart a counter or flip the open status.

// File: rtl/bank_timing_pkg.sv
package bank_timing_pkg;

    typedef enum logic [1:0] {
        CMD_ACT = 2'd0,
        CMD_RD  = 2'd1,
        CMD_WR  = 2'd2,
        CMD_PRE = 2'd3
    } bank_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRECHARGING,
        ST_OPENING,
        ST_ACTIVE
    } bank_state_e;

endpackage

// File: rtl/bank_elapsed_counter.sv
// Counts cycles since the last restart; holds at all ones.
module bank_elapsed_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] elapsed
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            elapsed <= '1;
        else if (restart)
            elapsed <= W'(1);
        else if (elapsed != '1)
            elapsed <= elapsed + W'(1);
    end
endmodule

// File: rtl/bank_read_return.sv
// Shift line marking the cycles in which read data is due.
module bank_read_return #(
    parameter int DEPTH = 16,
    parameter int W     = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] lat,
    output logic         due,
    output logic         busy
);
    logic [DEPTH-1:0] line_q;
    logic [DEPTH-1:0] line_d;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        if (i == DEPTH - 1) begin : g_top
            assign line_d[i] = push && (lat == W'(i + 1));
        end else begin : g_mid
            assign line_d[i] = line_q[i+1] | (push && (lat == W'(i + 1)));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            line_q <= '0;
        else
            line_q <= line_d;
    end

    assign due  = line_q[0];
    assign busy = |line_q;
endmodule

// File: rtl/bank_timing_guard.sv
module bank_timing_guard
    import bank_timing_pkg::*;
#(
    parameter int CNT_W   = 6,
    parameter int CL_MAX  = 16,
    parameter int DEF_CL  = 3,
    parameter int DEF_RCD = 4,
    parameter int DEF_RP  = 4,
    parameter int DEF_RAS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [CNT_W-1:0] cfg_cl,
    input  logic [CNT_W-1:0] cfg_rcd,
    input  logic [CNT_W-1:0] cfg_rp,
    input  logic [CNT_W-1:0] cfg_ras,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_type,
    output logic             allow_act,
    output logic             allow_rd,
    output logic             allow_wr,
    output logic             allow_pre,
    output logic             bank_open,
    output logic             rdata_expected
);
    localparam logic [CNT_W-1:0] CL_LIM   = CNT_W'(CL_MAX);
    localparam logic [CNT_W-1:0] RST_CL   = CNT_W'(DEF_CL);
    localparam logic [CNT_W-1:0] RST_RCD  = CNT_W'(DEF_RCD);
    localparam logic [CNT_W-1:0] RST_RP   = CNT_W'(DEF_RP);
    localparam logic [CNT_W-1:0] RST_RAS  = CNT_W'(DEF_RAS);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    bank_state_e      state_q, state_d;
    logic [CNT_W-1:0] cl_q, rcd_q, rp_q, ras_q;
    logic [CNT_W-1:0] act_cnt, pre_cnt;
    logic [CNT_W:0]   act_nxt, pre_nxt;
    logic             act_go, rd_go, pre_go, cfg_take, rd_busy;

    assign act_go = cmd_valid && (cmd_type == CMD_ACT) && allow_act;
    assign rd_go  = cmd_valid && (cmd_type == CMD_RD)  && allow_rd;
    assign pre_go = cmd_valid && (cmd_type == CMD_PRE) && allow_pre;

    assign act_nxt = {1'b0, act_cnt} + {{CNT_W{1'b0}}, 1'b1};
    assign pre_nxt = {1'b0, pre_cnt} + {{CNT_W{1'b0}}, 1'b1};

    bank_elapsed_counter #(.W(CNT_W)) u_since_act (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (act_go),
        .elapsed (act_cnt)
    );

    bank_elapsed_counter #(.W(CNT_W)) u_since_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (pre_go),
        .elapsed (pre_cnt)
    );

    bank_read_return #(.DEPTH(CL_MAX), .W(CNT_W)) u_rd_ret (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rd_go),
        .lat   (cl_q),
        .due   (rdata_expected),
        .busy  (rd_busy)
    );

    // Timing set: accepted only when closed, recovered and quiet.
    assign cfg_take = cfg_load && (state_q == ST_IDLE) && !rd_busy && !act_go
                      && (cfg_cl != '0) && (cfg_cl <= CL_LIM);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cl_q  <= RST_CL;
            rcd_q <= RST_RCD;
            rp_q  <= RST_RP;
            ras_q <= RST_RAS;
        end else if (cfg_take) begin
            cl_q  <= cfg_cl;
            rcd_q <= cfg_rcd;
            rp_q  <= cfg_rp;
            ras_q <= cfg_ras;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (act_go)
                    state_d = (rcd_q <= ONE) ? ST_ACTIVE : ST_OPENING;
            end
            ST_OPENING: begin
                if (pre_go)
                    state_d = (rp_q <= ONE) ? ST_IDLE : ST_PRECHARGING;
                else if (act_nxt >= {1'b0, rcd_q})
                    state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (pre_go)
                    state_d = (rp_q <= ONE) ? ST_IDLE : ST_PRECHARGING;
            end
            ST_PRECHARGING: begin
                if (pre_nxt >= {1'b0, rp_q})
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Outputs
    always_comb begin
        allow_act = 1'b0;
        allow_rd  = 1'b0;
        allow_wr  = 1'b0;
        allow_pre = 1'b0;
        bank_open = 1'b0;
        unique case (state_q)
            ST_IDLE: allow_act = 1'b1;
            ST_OPENING: begin
                bank_open = 1'b1;
                allow_pre = (act_cnt >= ras_q);
            end
            ST_ACTIVE: begin
                bank_open = 1'b1;
                allow_rd  = 1'b1;
                allow_wr  = 1'b1;
                allow_pre = (act_cnt >= ras_q);
            end
            ST_PRECHARGING: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/bank_timing_guard_chk.sv
module bank_timing_guard_chk #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [1:0]       cmd_type,
    input logic             allow_act,
    input logic             allow_rd,
    input logic             allow_wr,
    input logic             allow_pre,
    input logic             bank_open,
    input logic             rdata_expected,
    input logic [CNT_W-1:0] cl_q,
    input logic [CNT_W-1:0] rcd_q,
    input logic [CNT_W-1:0] ras_q
);
    logic act_issue, rd_issue, pre_issue;
    assign act_issue = cmd_valid && (cmd_type == 2'd0) && allow_act;
    assign rd_issue  = cmd_valid && (cmd_type == 2'd1) && allow_rd;
    assign pre_issue = cmd_valid && (cmd_type == 2'd3) && allow_pre;

    a_r3_access_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
        (allow_rd || allow_wr) |-> bank_open);

    a_r5_open_needs_closed: assert property (@(posedge clk) disable iff (!rst_n)
        allow_act |-> !bank_open);

    a_r4_close_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
        allow_pre |-> bank_open);

    a_r8_open_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        act_issue |=> bank_open);

    a_r8_close_clears_status: assert property (@(posedge clk) disable iff (!rst_n)
        pre_issue |=> !bank_open);

    a_r3_access_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (act_issue && (rcd_q > 1)) |=> !allow_rd);

    a_r4_close_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (act_issue && (ras_q > 1)) |=> !allow_pre);

    a_r6_short_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_issue && (cl_q == 1)) |=> rdata_expected);

    a_r2_refused_read_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_type == 2'd1) && !bank_open) |=> !bank_open);
endmodule

bind bank_timing_guard bank_timing_guard_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/bank_timing_guard_tb.sv
module bank_timing_guard_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0;
    logic [5:0] cfg_cl = '0, cfg_rcd = '0, cfg_rp = '0, cfg_ras = '0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_type = '0;
    logic       allow_act, allow_rd, allow_wr, allow_pre, bank_open, rdata_expected;

    always #10 clk = ~clk;

    bank_timing_guard dut_i (.*);

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // reference model state
    int  cyc = 0;
    bit  m_open = 0, m_ready = 1;
    int  t_act = -1000, t_pre = -1000, last_due = -1;
    int  m_cl = 3, m_rcd = 4, m_rp = 4, m_ras = 8;
    bit  due_q [256];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d",
                     req, what, cyc, act, exp);
        end
    endtask

    function automatic bit exp_act();
        return !m_open && (m_ready || (cyc - t_pre) >= m_rp);
    endfunction
    function automatic bit exp_acc();
        return m_open && (cyc - t_act) >= m_rcd;
    endfunction
    function automatic bit exp_pre();
        return m_open && (cyc - t_act) >= m_ras;
    endfunction

    // Compare current outputs (taken at a falling edge), drive, advance model.
    task automatic step(input bit v, input int t, input bit ld,
                        input int cl, input int rcd, input int rp, input int ras);
        bit ea, eacc, ep, er;
        ea = exp_act(); eacc = exp_acc(); ep = exp_pre();
        er = due_q[cyc % 256];
        due_q[cyc % 256] = 0;
        if (ea) m_ready = 1;
        chk(allow_act == ea,   "R5", "allow_act", allow_act, ea);
        chk(allow_rd  == eacc, "R3", "allow_rd",  allow_rd,  eacc);
        chk(allow_wr  == eacc, "R3", "allow_wr",  allow_wr,  eacc);
        chk(allow_pre == ep,   "R4", "allow_pre", allow_pre, ep);
        chk(bank_open == m_open, "R8", "bank_open", bank_open, m_open);
        chk(rdata_expected == er, "R6", "rdata_expected", rdata_expected, er);
        cmd_valid = v; cmd_type = 2'(t); cfg_load = ld;
        cfg_cl = 6'(cl); cfg_rcd = 6'(rcd); cfg_rp = 6'(rp); cfg_ras = 6'(ras);
        // R7 acceptance rule
        if (ld && ea && (last_due < cyc) && !(v && t == 0) && cl >= 1 && cl <= 16) begin
            m_cl = cl; m_rcd = rcd; m_rp = rp; m_ras = ras;
        end
        // R2: only allowed commands take effect
        if (v && t == 0 && ea) begin m_open = 1; t_act = cyc; m_ready = 0; end
        if (v && t == 1 && eacc) begin
            due_q[(cyc + m_cl) % 256] = 1;
            if (cyc + m_cl > last_due) last_due = cyc + m_cl;
        end
        if (v && t == 3 && ep) begin m_open = 0; t_pre = cyc; m_ready = 0; end
        cyc++;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", cyc);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(allow_act == 1 && !allow_rd && !allow_wr && !allow_pre, "R1", "allows",
            {allow_act, allow_rd, allow_wr, allow_pre}, 4'b1000);
        chk(!bank_open && !rdata_expected, "R1", "status", {bank_open, rdata_expected}, 0);
        // R2: refused read to closed bank
        step(1, 1, 0, 0, 0, 0, 0);
        chk(bank_open == 0 && allow_act == 1, "R2", "refused read", bank_open, 0);
        // open at cycle c, try a load while open (R7), then walk the windows
        step(1, 0, 0, 0, 0, 0, 0);                 // c
        step(0, 0, 1, 2, 2, 2, 5);                 // c+1, load ignored
        chk(allow_rd == 0, "R3", "rd at c+2", allow_rd, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        chk(allow_rd == 0, "R7", "rd at c+3 after refused load", allow_rd, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        chk(allow_rd == 1, "R3", "rd at c+4", allow_rd, 1);
        step(1, 1, 0, 0, 0, 0, 0);                 // read at c+4
        step(1, 1, 0, 0, 0, 0, 0);                 // read at c+5
        idle(1);
        chk(rdata_expected == 1, "R6", "data at c+7", rdata_expected, 1);
        chk(allow_pre == 0, "R4", "close at c+7", allow_pre, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        chk(allow_pre == 1, "R4", "close at c+8", allow_pre, 1);
        chk(rdata_expected == 1, "R6", "back-to-back data at c+8", rdata_expected, 1);
        step(1, 3, 0, 0, 0, 0, 0);                 // close at c+8
        chk(bank_open == 0 && allow_act == 0, "R8", "closed at c+9", bank_open, 0);
        idle(2);
        chk(allow_act == 0, "R5", "open at c+11", allow_act, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        chk(allow_act == 1, "R5", "open at c+12", allow_act, 1);
        // R7: accepted fast load, then open and probe the new window
        step(0, 0, 1, 2, 2, 2, 5);
        step(1, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        chk(allow_rd == 1, "R7", "rd two cycles after open", allow_rd, 1);
        step(1, 3, 0, 0, 0, 0, 0);                 // refused close (R2)
        chk(bank_open == 1, "R2", "refused close", bank_open, 1);
        idle(4);
        // random mix against the model
        void'($urandom(32'h5eed_b41c));
        for (int i = 0; i < 6000; i++) begin
            int v, t, ld, sel, cl, rcd, rp, ras;
            v  = ($urandom % 10) < 7;
            t  = $urandom % 4;
            ld = ($urandom % 20) == 0;
            sel = $urandom % 4;
            case (sel)
                0: begin cl = 3; rcd = 4; rp = 4; ras = 8; end
                1: begin cl = 2; rcd = 2; rp = 2; ras = 5; end
                2: begin cl = 9; rcd = 9; rp = 9; ras = 27; end
                default: begin
                    cl = $urandom % 19; rcd = $urandom % 12;
                    rp = $urandom % 12; ras = $urandom % 30;
                end
            endcase
            step(v[0], t, ld[0], cl, rcd, rp, ras);
        end
        idle(40);
        finish_run();
    end
endmodule